// File: doc/BRIEF.md
# Converter Start-Up Sequencer

This block orders the start-up of a switching regulator. It watches two qualifying flags: a supply-good flag from a power-on comparator and a run-enable flag from the shutdown pin's comparator. When both are high, it steps through a fixed set of phases:

1. A settling delay while the low-side gate driver is held off.
2. A sample phase of variable length. During this phase it asks an external overcurrent sample-and-hold to capture its trip level and waits for that block's done strobe.
3. A short fixed gap.
4. The soft-start phase. Here it enables the error amplifier and lets the reference ramp run until the ramp reports completion.

If shutdown is held low at power-up, start-up simply waits until shutdown is released. Losing either flag at any moment sends the sequencer straight back to idle. From idle, the low-side driver is disabled again and every enable is cleared.

Fixed delays are counted in ticks of an internal prescaler. The settling and gap lengths are parameters given in ticks. With the default 125 MHz clock, one tick is about 106 µs, so the 64-tick settle gives about 6.8 ms and the 32-tick gap gives about 3.4 ms. The current phase is exported as a three-bit code, so the order of phases can be observed.

Top module: `pwrup_seq`

## Requirements
- R1: While reset is high, and in the idle phase, `phase` reads 0, `lsd_off` is 1, and `sh_start`, `ea_en` and `ss_start` are 0.
- R2: The sequencer stays in idle for as long as `supply_ok` or `run_en` is low. The first clock edge that sees both high moves `phase` to 1. A late `run_en` only postpones start-up.
- R3: The settle phase (`phase` = 1) lasts exactly SETTLE_TICKS × TICK_DIV clock cycles, with `lsd_off` = 1 and `sh_start` = 0.
- R4: In the sample phase (`phase` = 2), `sh_start` and `lsd_off` are 1. The edge that sees `sh_done` high moves `phase` to 3, even on the sample phase's first cycle (a sample of zero length).
- R5: `sh_done` has no effect outside the sample phase, and `ss_done` has no effect outside the soft-start phase.
- R6: The gap phase (`phase` = 3) lasts exactly GAP_TICKS × TICK_DIV cycles, with `lsd_off` = 1 and `sh_start`, `ea_en` and `ss_start` all 0.
- R7: In soft-start (`phase` = 4) and in run (`phase` = 5), `ea_en` and `ss_start` are 1 and `lsd_off` is 0. The edge that sees `ss_done` in soft-start moves `phase` to 5.
- R8: If `supply_ok` or `run_en` is low at a clock edge, `phase` becomes 0 with the R1 outputs. This takes priority over any other transition due on that same edge.
- R9: `phase` changes only to its previous value plus one, or to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Bias supply above its rising power-on threshold |
| run_en | input | 1 | Shutdown pin released above its disable level |
| sh_done | input | 1 | Done strobe from the overcurrent sample-and-hold |
| ss_done | input | 1 | Soft-start ramp has reached its final value |
| sh_start | output | 1 | Request to the sample-and-hold to capture the trip level |
| lsd_off | output | 1 | Holds the low-side gate driver disabled |
| ea_en | output | 1 | Error amplifier enable |
| ss_start | output | 1 | Soft-start ramp run |
| phase | output | 3 | Current phase: 0 idle, 1 settle, 2 sample, 3 gap, 4 soft-start, 5 run |

## Verification
A loss of `supply_ok` or `run_en` can land on the same edge as a forward transition. The bench provokes this two ways:
- It drops `run_en` in the last cycle of the settle delay, when the delay is about to expire.
- It drops `run_en` in the very cycle that `sh_done` is pulsed during sampling.

In both cases the phase must be 0 after that edge and never 2 or 3. A behavioural reference model, advanced every clock, judges every cycle around these collisions. Directed checks confirm the reset-wins outcome.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETTLE = 3'd1,
    PH_SAMPLE = 3'd2,
    PH_GAP    = 3'd3,
    PH_SOFT   = 3'd4,
    PH_RUN    = 3'd5
  } phase_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pwrup_tick.sv
module pwrup_tick #(
  parameter int TICK_DIV = 13281
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  generate
    if (TICK_DIV <= 1) begin : g_passthru
      assign tick = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(TICK_DIV);
      localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);
      logic [PW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (rst || clr || cnt_q == LAST) cnt_q <= '0;
        else                             cnt_q <= cnt_q + PW'(1);
      end
      assign tick = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/pwrup_dly.sv
module pwrup_dly #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          expire
);
  logic [CW-1:0] ticks_q;
  always_ff @(posedge clk) begin
    if (rst || clr)  ticks_q <= '0;
    else if (tick)   ticks_q <= ticks_q + CW'(1);
  end
  assign expire = tick && (ticks_q == limit - CW'(1));
endmodule

// File: rtl/pwrup_fsm.sv
module pwrup_fsm
  import pwrup_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       supply_ok,
  input  logic       run_en,
  input  logic       sh_done,
  input  logic       ss_done,
  input  logic       expire,
  output logic       restart,
  output logic       in_settle,
  output logic       sh_start,
  output logic       lsd_off,
  output logic       ea_en,
  output logic       ss_start,
  output logic [2:0] phase
);
  phase_e state_q, state_d;
  logic   go;

  assign go = supply_ok && run_en;

  always_comb begin
    state_d = state_q;
    if (!go) state_d = PH_IDLE;
    else begin
      unique case (state_q)
        PH_IDLE:   state_d = PH_SETTLE;
        PH_SETTLE: if (expire)  state_d = PH_SAMPLE;
        PH_SAMPLE: if (sh_done) state_d = PH_GAP;
        PH_GAP:    if (expire)  state_d = PH_SOFT;
        PH_SOFT:   if (ss_done) state_d = PH_RUN;
        PH_RUN:    state_d = PH_RUN;
        default:   state_d = PH_IDLE;
      endcase
    end
  end

  assign restart   = (state_d != state_q);
  assign in_settle = (state_q == PH_SETTLE);
  assign phase     = state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= PH_IDLE;
      lsd_off  <= 1'b1;
      sh_start <= 1'b0;
      ea_en    <= 1'b0;
      ss_start <= 1'b0;
    end else begin
      state_q  <= state_d;
      lsd_off  <= (state_d == PH_IDLE) || (state_d == PH_SETTLE) ||
                  (state_d == PH_SAMPLE) || (state_d == PH_GAP);
      sh_start <= (state_d == PH_SAMPLE);
      ea_en    <= (state_d == PH_SOFT) || (state_d == PH_RUN);
      ss_start <= (state_d == PH_SOFT) || (state_d == PH_RUN);
    end
  end

  // R8
  drop_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !(supply_ok && run_en) |=> (phase == 3'd0) && lsd_off && !ea_en && !sh_start);
  // R4
  sample_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == PH_SAMPLE) && sh_done && go |=> (phase == 3'd3));
  // R5
  settle_ignores_done_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == PH_SETTLE) && !expire && go |=> (phase == 3'd1));
  // R7
  drv_vs_amp_chk: assert property (@(posedge clk) disable iff (rst)
    ea_en |-> !lsd_off);
  // R9
  phase_order_chk: assert property (@(posedge clk) disable iff (rst)
    (phase != $past(phase)) |-> (phase == 3'd0) || (phase == $past(phase) + 3'd1));
endmodule

// File: rtl/pwrup_seq.sv
module pwrup_seq
  import pwrup_pkg::*;
#(
  parameter int TICK_DIV     = 13281,
  parameter int SETTLE_TICKS = 64,
  parameter int GAP_TICKS    = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       supply_ok,
  input  logic       run_en,
  input  logic       sh_done,
  input  logic       ss_done,
  output logic       sh_start,
  output logic       lsd_off,
  output logic       ea_en,
  output logic       ss_start,
  output logic [2:0] phase
);
  localparam int CW = $clog2(max2(SETTLE_TICKS, GAP_TICKS) + 1);
  localparam logic [CW-1:0] SETTLE_LIM = CW'(SETTLE_TICKS);
  localparam logic [CW-1:0] GAP_LIM    = CW'(GAP_TICKS);

  logic restart, in_settle, tick, expire;
  logic [CW-1:0] limit;

  assign limit = in_settle ? SETTLE_LIM : GAP_LIM;

  pwrup_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .clr(restart), .tick(tick)
  );

  pwrup_dly #(.CW(CW)) u_dly (
    .clk(clk), .rst(rst), .clr(restart), .tick(tick),
    .limit(limit), .expire(expire)
  );

  pwrup_fsm u_fsm (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .run_en(run_en),
    .sh_done(sh_done), .ss_done(ss_done), .expire(expire),
    .restart(restart), .in_settle(in_settle),
    .sh_start(sh_start), .lsd_off(lsd_off), .ea_en(ea_en),
    .ss_start(ss_start), .phase(phase)
  );
endmodule

// File: tb/pwrup_seq_tb.sv
module pwrup_seq_tb;
  localparam int TICK_DIV     = 4;
  localparam int SETTLE_TICKS = 8;
  localparam int GAP_TICKS    = 3;
  localparam int SETTLE_CYC   = TICK_DIV * SETTLE_TICKS;
  localparam int GAP_CYC      = TICK_DIV * GAP_TICKS;

  logic clk = 1'b0;
  logic rst, sup, en, shd, ssd;
  logic sh_start, lsd_off, ea_en, ss_start;
  logic [2:0] phase;

  int checks = 0, errors = 0;
  int m_ph = 0, m_cnt = 0, nx = 0;
  bit armed = 1'b0;
  int prev_ph = 0;

  always #4 clk = ~clk;

  pwrup_seq #(.TICK_DIV(TICK_DIV), .SETTLE_TICKS(SETTLE_TICKS), .GAP_TICKS(GAP_TICKS)) u_dut (
    .clk(clk), .rst(rst), .supply_ok(sup), .run_en(en), .sh_done(shd), .ss_done(ssd),
    .sh_start(sh_start), .lsd_off(lsd_off), .ea_en(ea_en), .ss_start(ss_start), .phase(phase)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input int ph);
    case (ph)
      0: return "R1 idle outputs";
      1: return "R3 settle outputs";
      2: return "R4 sample outputs";
      3: return "R6 gap outputs";
      default: return "R7 soft/run outputs";
    endcase
  endfunction

  // reference model, advanced on every clock
  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_cnt = 0;
    end else begin
      nx = m_ph;
      if (!(sup && en)) nx = 0;
      else case (m_ph)
        0: nx = 1;
        1: if (m_cnt == SETTLE_CYC - 1) nx = 2;
        2: if (shd) nx = 3;
        3: if (m_cnt == GAP_CYC - 1) nx = 4;
        4: if (ssd) nx = 5;
        default: ;
      endcase
      m_cnt = (nx != m_ph) ? 0 : m_cnt + 1;
      m_ph  = nx;
    end
  end

  // per-cycle comparison and phase order
  always @(negedge clk) begin
    if (armed) begin
      chk(tag_of(m_ph), {phase, lsd_off, sh_start, ea_en, ss_start},
          {m_ph[2:0], (m_ph <= 3), (m_ph == 2), (m_ph >= 4), (m_ph >= 4)});
      if (int'(phase) != prev_ph)
        chk("R9 phase order", int'((phase == 3'd0) || (int'(phase) == prev_ph + 1)), 1);
      prev_ph = int'(phase);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    rst = 1; sup = 0; en = 0; shd = 0; ssd = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {phase, lsd_off, sh_start, ea_en, ss_start}, {3'd0, 4'b1000});
    rst = 0; armed = 1;

    // R2: supply up, shutdown held low
    sup = 1;
    repeat (20) @(negedge clk);
    chk("R2 held by run_en", phase, 0);
    en = 1;
    @(negedge clk);
    chk("R2 start after release", phase, 1);

    // R3 length, R5 sh_done in settle ignored
    n = 0;
    while (phase == 3'd1) begin shd = (n == 10); n++; @(negedge clk); end
    shd = 0;
    chk("R3 settle length", n, SETTLE_CYC);
    chk("R5 sh_done in settle ignored, sample entered", phase, 2);
    repeat (5) @(negedge clk);
    chk("R4 sample waits for done", {phase, sh_start}, {3'd2, 1'b1});
    shd = 1; @(negedge clk); shd = 0;
    chk("R4 sample exit", phase, 3);

    // R6 length, R5 ss_done in gap ignored
    n = 0;
    while (phase == 3'd3) begin ssd = (n == 2); n++; @(negedge clk); end
    ssd = 0;
    chk("R6 gap length", n, GAP_CYC);
    chk("R5 ss_done in gap ignored, soft entered", phase, 4);
    repeat (4) @(negedge clk);
    ssd = 1; @(negedge clk); ssd = 0;
    chk("R7 run reached", {phase, ea_en, lsd_off}, {3'd5, 1'b1, 1'b0});
    repeat (3) @(negedge clk);
    sup = 0; @(negedge clk);
    chk("R8 supply loss in run", {phase, lsd_off, ea_en}, {3'd0, 1'b1, 1'b0});

    // R4 zero-length sample
    sup = 1;
    while (phase != 3'd2) @(negedge clk);
    shd = 1; @(negedge clk); shd = 0;
    chk("R4 zero-length sample", phase, 3);
    repeat (3) @(negedge clk);
    en = 0; @(negedge clk);
    chk("R8 enable loss in gap", phase, 0);
    en = 1;

    // R8 collision with sh_done
    while (phase != 3'd2) @(negedge clk);
    repeat (2) @(negedge clk);
    shd = 1; en = 0; @(negedge clk); shd = 0;
    chk("R8 reset wins over sh_done", phase, 0);
    en = 1;

    // R8 collision with settle expiry
    while (phase != 3'd1) @(negedge clk);
    repeat (SETTLE_CYC - 1) @(negedge clk);
    en = 0; @(negedge clk);
    chk("R8 reset wins over settle expiry", phase, 0);
    en = 1;

    // R8 loss during soft-start
    while (phase != 3'd2) @(negedge clk);
    shd = 1; @(negedge clk); shd = 0;
    while (phase != 3'd4) @(negedge clk);
    repeat (2) @(negedge clk);
    sup = 0; @(negedge clk);
    chk("R8 supply loss in soft-start", {phase, ss_start}, {3'd0, 1'b0});
    repeat (2) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule